// File: doc/BRIEF.md
# I2C Message Sequencer

This block runs one whole I2C message, read or write, on top of a byte-level master that reports each bus event as an 8-bit status code. The caller supplies the target address, the direction, a flag that selects 10-bit addressing, and a byte count, then pulses a start input. The sequencer asks the byte master for a START condition. It then sends one or two address bytes and moves the data bytes. At the end it asks for a STOP and raises a one-cycle done pulse with a result code.

Each next step is chosen from the status code the byte master posts. Outgoing data bytes are pulled from a local buffer through a valid/ready port. Incoming bytes are offered to the buffer through a second valid/ready port. When a read reaches its last byte, the sequencer withdraws the acknowledge bit beforehand, so that the final byte is NACKed on the bus. A read with a count of zero ends right after the address is acknowledged, which makes it usable as a device probe.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After a synchronous reset the block is idle: busy_o=0, done_o=0, bm_cmd_valid_o=0, tx_ready_o=0, rx_valid_o=0, err_o=0.
- R2: A start_i pulse while idle produces, one cycle later, bm_cmd_valid_o=1 with bm_cmd_o=1 (START) and busy_o=1. A start_i pulse while busy has no effect.
- R3: In 7-bit mode the first address byte is {addr[6:0], dir}, where dir=1 means read. It is sent with bm_cmd_o=2 (TX) after status 0x08 or 0x10.
- R4: In 10-bit mode the first address byte is {5'b11110, addr[9:8], dir}. After status 0x18 (write) or 0x40 (read), the second address byte addr[7:0] is sent with TX. Statuses 0xD0 and 0xE0 then mark the second address as acknowledged.
- R5: A write acknowledge status (0x18 in 7-bit mode, 0xD0, 0x28) with bytes remaining raises tx_ready_o and waits for tx_valid_i. It then sends tx_data_i with TX and decrements the count. With no bytes remaining it issues STOP (bm_cmd_o=4) with done_o=1 and err_o=0.
- R6: A read-address acknowledge with bytes remaining issues RX (bm_cmd_o=3). bm_ack_o=0 is set for the next byte exactly when one byte remains, and bm_ack_o=1 otherwise. Status 0x50 delivers bm_rx_byte_i on the rx port and then issues RX. Status 0x58 delivers the byte and then issues STOP with done_o=1 and err_o=0.
- R7: A read with a count of zero issues STOP with done_o=1 and err_o=0 directly after the address acknowledge.
- R8: Status 0x20, 0x30 or 0x48 during a transfer issues STOP, ends the transfer with done_o=1 and sets err_o=1 (no device).
- R9: Any other unexpected status during a transfer (for example 0x38 or 0xD8) issues ABORT (bm_cmd_o=5), meaning stop and reinitialise the byte master. It ends the transfer with done_o=1 and sets err_o=2 (I/O error).
- R10: A status arriving while idle issues STOP without a done pulse and leaves err_o unchanged.
- R11: err_o keeps its value until the next accepted start_i, which clears it to 0.
- R12: While rx_valid_o=1 and rx_ready_i=0, rx_valid_o and rx_data_o hold steady and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a message (accepted only while idle) |
| addr_i | input | 10 | Target address |
| rd_i | input | 1 | 1 = read, 0 = write |
| ten_i | input | 1 | 1 = 10-bit addressing |
| len_i | input | LEN_W | Number of data bytes |
| busy_o | output | 1 | A message is in progress |
| done_o | output | 1 | One-cycle pulse when a message ends |
| err_o | output | 2 | Result: 0 ok, 1 no device, 2 I/O error |
| bm_cmd_valid_o | output | 1 | One-cycle command strobe to the byte master |
| bm_cmd_o | output | 3 | 1 START, 2 TX, 3 RX, 4 STOP, 5 ABORT |
| bm_tx_byte_o | output | 8 | Byte to send with TX |
| bm_ack_o | output | 1 | Acknowledge bit for the next received byte |
| bm_status_valid_i | input | 1 | Byte master posts a status |
| bm_status_i | input | 8 | Status code |
| bm_rx_byte_i | input | 8 | Received byte, valid with status 0x50/0x58 |
| tx_valid_i | input | 1 | Buffer offers an outgoing byte |
| tx_data_i | input | 8 | Outgoing byte |
| tx_ready_o | output | 1 | Sequencer takes the outgoing byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_data_o | output | 8 | Received byte |
| rx_ready_i | input | 1 | Buffer accepts the received byte |

## Verification
The hardest situation to reach is the ACK bit when the read count is about to run out. The bit must drop exactly when one byte remains, both on the very first RX command of a one-byte read and on the RX command issued after each delivered byte. It must also survive a stalled receive buffer. The bench plays the byte master itself and sweeps read lengths from 0 to 4, in both address modes, over several addresses. It holds rx_ready_i low for several cycles on every byte and predicts the ACK bit from the remaining count at each step. The NACK, unexpected-status and idle-status paths are reached by posting those codes at chosen points mid-message.

// File: rtl/i2c_xfer_seq_pkg.sv
package i2c_xfer_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_START = 3'd1,
    CMD_TX    = 3'd2,
    CMD_RX    = 3'd3,
    CMD_STOP  = 3'd4,
    CMD_ABORT = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_NODEV = 2'd1,
    RES_IO    = 2'd2
  } res_e;

  typedef enum logic [3:0] {
    EV_START, EV_WADDR_ACK, EV_WADDR2_ACK, EV_WDATA_ACK,
    EV_RADDR_ACK, EV_RADDR2_ACK, EV_RDATA_ACK, EV_RDATA_NAK,
    EV_NAK, EV_BAD
  } ev_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_START, ST_WAIT_A1, ST_WAIT_A2,
    ST_WAIT_SACK, ST_WAIT_SDATA, ST_FETCH, ST_DELIVER
  } st_e;

  localparam logic [7:0] SC_START    = 8'h08;
  localparam logic [7:0] SC_RESTART  = 8'h10;
  localparam logic [7:0] SC_WA_ACK   = 8'h18;
  localparam logic [7:0] SC_WA_NAK   = 8'h20;
  localparam logic [7:0] SC_WD_ACK   = 8'h28;
  localparam logic [7:0] SC_WD_NAK   = 8'h30;
  localparam logic [7:0] SC_RA_ACK   = 8'h40;
  localparam logic [7:0] SC_RA_NAK   = 8'h48;
  localparam logic [7:0] SC_RD_ACK   = 8'h50;
  localparam logic [7:0] SC_RD_NAK   = 8'h58;
  localparam logic [7:0] SC_WA2_ACK  = 8'hD0;
  localparam logic [7:0] SC_RA2_ACK  = 8'hE0;

endpackage

// File: rtl/i2c_xfer_seq_addr.sv
module i2c_xfer_seq_addr #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          ten,
  output logic [7:0]    first_byte,
  output logic [7:0]    second_byte
);
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  always_comb begin
    if (ten) begin
      first_byte  = {TEN_PREFIX, addr[9:8], rd};
      second_byte = addr[7:0];
    end else begin
      first_byte  = {addr[6:0], rd};
      second_byte = 8'h00;
    end
  end
endmodule

// File: rtl/i2c_xfer_seq_decode.sv
module i2c_xfer_seq_decode
  import i2c_xfer_seq_pkg::*;
(
  input  logic [7:0] status,
  output ev_e        ev
);
  always_comb begin
    unique case (status)
      SC_START, SC_RESTART:           ev = EV_START;
      SC_WA_ACK:                      ev = EV_WADDR_ACK;
      SC_WA2_ACK:                     ev = EV_WADDR2_ACK;
      SC_WD_ACK:                      ev = EV_WDATA_ACK;
      SC_RA_ACK:                      ev = EV_RADDR_ACK;
      SC_RA2_ACK:                     ev = EV_RADDR2_ACK;
      SC_RD_ACK:                      ev = EV_RDATA_ACK;
      SC_RD_NAK:                      ev = EV_RDATA_NAK;
      SC_WA_NAK, SC_WD_NAK, SC_RA_NAK: ev = EV_NAK;
      default:                        ev = EV_BAD;
    endcase
  end
endmodule

// File: rtl/i2c_xfer_seq_count.sv
module i2c_xfer_seq_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero,
  output logic         is_one,
  output logic         is_two
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)       left_q <= '0;
    else if (load) left_q <= load_val;
    else if (dec && left_q != '0) left_q <= left_q - W'(1);
  end

  assign is_zero = (left_q == '0);
  assign is_one  = (left_q == W'(1));
  assign is_two  = (left_q == W'(2));
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_xfer_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [9:0]       addr_i,
  input  logic             rd_i,
  input  logic             ten_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       err_o,
  output logic             bm_cmd_valid_o,
  output logic [2:0]       bm_cmd_o,
  output logic [7:0]       bm_tx_byte_o,
  output logic             bm_ack_o,
  input  logic             bm_status_valid_i,
  input  logic [7:0]       bm_status_i,
  input  logic [7:0]       bm_rx_byte_i,
  input  logic             tx_valid_i,
  input  logic [7:0]       tx_data_i,
  output logic             tx_ready_o,
  output logic             rx_valid_o,
  output logic [7:0]       rx_data_o,
  input  logic             rx_ready_i
);
  localparam int AW = 10;

  st_e        state_q;
  logic       cmd_valid_q, done_q, ack_q, rxv_q, last_q, ten_q;
  logic [2:0] cmd_q;
  logic [7:0] txb_q, rxd_q, a1_q, a2_q;
  logic [1:0] err_q;

  logic [7:0] a1, a2;
  ev_e        ev;
  logic       cnt_zero, cnt_one, cnt_two;
  logic       in_wait, take_status, cnt_load, cnt_dec;

  i2c_xfer_seq_addr #(.AW(AW)) u_addr (
    .addr(addr_i), .rd(rd_i), .ten(ten_i),
    .first_byte(a1), .second_byte(a2)
  );

  i2c_xfer_seq_decode u_dec (.status(bm_status_i), .ev(ev));

  i2c_xfer_seq_count #(.W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(len_i), .dec(cnt_dec),
    .is_zero(cnt_zero), .is_one(cnt_one), .is_two(cnt_two)
  );

  always_comb begin
    in_wait     = (state_q == ST_WAIT_START) || (state_q == ST_WAIT_A1) ||
                  (state_q == ST_WAIT_A2)    || (state_q == ST_WAIT_SACK) ||
                  (state_q == ST_WAIT_SDATA);
    take_status = in_wait && bm_status_valid_i;
    cnt_load    = (state_q == ST_IDLE) && start_i;
    cnt_dec     = ((state_q == ST_FETCH) && tx_valid_i) ||
                  (take_status && (ev == EV_RDATA_ACK || ev == EV_RDATA_NAK));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cmd_valid_q <= 1'b0;
      cmd_q       <= CMD_NONE;
      txb_q       <= 8'h00;
      ack_q       <= 1'b1;
      done_q      <= 1'b0;
      err_q       <= RES_OK;
      rxv_q       <= 1'b0;
      rxd_q       <= 8'h00;
      last_q      <= 1'b0;
      ten_q       <= 1'b0;
      a1_q        <= 8'h00;
      a2_q        <= 8'h00;
    end else begin
      cmd_valid_q <= 1'b0;
      done_q      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            a1_q        <= a1;
            a2_q        <= a2;
            ten_q       <= ten_i;
            ack_q       <= 1'b1;
            err_q       <= RES_OK;
            cmd_valid_q <= 1'b1;
            cmd_q       <= CMD_START;
            state_q     <= ST_WAIT_START;
          end else if (bm_status_valid_i) begin
            cmd_valid_q <= 1'b1;
            cmd_q       <= CMD_STOP;
          end
        end
        ST_FETCH: begin
          if (tx_valid_i) begin
            cmd_valid_q <= 1'b1;
            cmd_q       <= CMD_TX;
            txb_q       <= tx_data_i;
            state_q     <= ST_WAIT_SACK;
          end
        end
        ST_DELIVER: begin
          if (rx_ready_i) begin
            rxv_q       <= 1'b0;
            cmd_valid_q <= 1'b1;
            if (last_q) begin
              cmd_q   <= CMD_STOP;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cmd_q   <= CMD_RX;
              state_q <= ST_WAIT_SDATA;
            end
          end
        end
        default: begin
          if (bm_status_valid_i) begin
            cmd_valid_q <= 1'b1;
            unique case (ev)
              EV_START: begin
                cmd_q   <= CMD_TX;
                txb_q   <= a1_q;
                state_q <= ST_WAIT_A1;
              end
              EV_WADDR_ACK, EV_WADDR2_ACK, EV_WDATA_ACK: begin
                if (ev == EV_WADDR_ACK && ten_q) begin
                  cmd_q   <= CMD_TX;
                  txb_q   <= a2_q;
                  state_q <= ST_WAIT_A2;
                end else if (cnt_zero) begin
                  cmd_q   <= CMD_STOP;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
                end else begin
                  cmd_valid_q <= 1'b0;
                  state_q     <= ST_FETCH;
                end
              end
              EV_RADDR_ACK, EV_RADDR2_ACK: begin
                if (ev == EV_RADDR_ACK && ten_q) begin
                  cmd_q   <= CMD_TX;
                  txb_q   <= a2_q;
                  state_q <= ST_WAIT_A2;
                end else if (cnt_zero) begin
                  cmd_q   <= CMD_STOP;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
                end else begin
                  cmd_q   <= CMD_RX;
                  ack_q   <= !cnt_one;
                  state_q <= ST_WAIT_SDATA;
                end
              end
              EV_RDATA_ACK, EV_RDATA_NAK: begin
                cmd_valid_q <= 1'b0;
                rxv_q       <= 1'b1;
                rxd_q       <= bm_rx_byte_i;
                last_q      <= (ev == EV_RDATA_NAK);
                ack_q       <= !cnt_two;
                state_q     <= ST_DELIVER;
              end
              EV_NAK: begin
                cmd_q   <= CMD_STOP;
                done_q  <= 1'b1;
                err_q   <= RES_NODEV;
                state_q <= ST_IDLE;
              end
              default: begin
                cmd_q   <= CMD_ABORT;
                done_q  <= 1'b1;
                err_q   <= RES_IO;
                state_q <= ST_IDLE;
              end
            endcase
          end
        end
      endcase
    end
  end

  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = done_q;
  assign err_o          = err_q;
  assign bm_cmd_valid_o = cmd_valid_q;
  assign bm_cmd_o       = cmd_q;
  assign bm_tx_byte_o   = txb_q;
  assign bm_ack_o       = ack_q;
  assign tx_ready_o     = (state_q == ST_FETCH);
  assign rx_valid_o     = rxv_q;
  assign rx_data_o      = rxd_q;
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] err_o,
  input logic       bm_cmd_valid_o,
  input logic [2:0] bm_cmd_o,
  input logic       bm_status_valid_i,
  input logic [7:0] bm_status_i,
  input logic       tx_ready_o,
  input logic       rx_valid_o,
  input logic [7:0] rx_data_o,
  input logic       rx_ready_i
);
  p_start_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (bm_cmd_valid_o && bm_cmd_o == 3'd1 && busy_o));

  p_done_with_stop_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (bm_cmd_valid_o && (bm_cmd_o == 3'd4 || bm_cmd_o == 3'd5) && !busy_o));

  p_nodev_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && bm_status_valid_i && !tx_ready_o && !rx_valid_o &&
     (bm_status_i == 8'h20 || bm_status_i == 8'h30 || bm_status_i == 8'h48))
    |=> (done_o && err_o == 2'd1 && bm_cmd_o == 3'd4));

  p_io_err_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && bm_status_valid_i && !tx_ready_o && !rx_valid_o && bm_status_i == 8'h38)
    |=> (done_o && err_o == 2'd2 && bm_cmd_o == 3'd5));

  p_idle_status_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i && bm_status_valid_i)
    |=> (bm_cmd_valid_o && bm_cmd_o == 3'd4 && !done_o));

  p_err_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(err_o));

  p_rx_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o) && !bm_cmd_valid_o));

  p_port_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(tx_ready_o && rx_valid_o));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .bm_cmd_valid_o(bm_cmd_valid_o), .bm_cmd_o(bm_cmd_o),
  .bm_status_valid_i(bm_status_valid_i), .bm_status_i(bm_status_i),
  .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
  .rx_ready_i(rx_ready_i)
);

// File: tb/tb_i2c_xfer_seq.sv
`timescale 1ns/1ps
module tb_i2c_xfer_seq;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, rd_i = 0, ten_i = 0;
  logic [9:0] addr_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic busy_o, done_o, bm_cmd_valid_o, bm_ack_o;
  logic [1:0] err_o;
  logic [2:0] bm_cmd_o;
  logic [7:0] bm_tx_byte_o;
  logic bm_status_valid_i = 0;
  logic [7:0] bm_status_i = '0, bm_rx_byte_i = '0;
  logic tx_valid_i = 0;
  logic [7:0] tx_data_i = '0;
  logic tx_ready_o, rx_valid_o;
  logic [7:0] rx_data_o;
  logic rx_ready_i = 0;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_xfer_seq #(.LEN_W(LEN_W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  // expect a command strobe in the current (post-edge) cycle
  task automatic exp_cmd(input string req, input int cmd, input int byte_v);
    chk({req, " cmd_valid"}, bm_cmd_valid_o, 1);
    chk({req, " cmd"}, bm_cmd_o, cmd);
    if (byte_v >= 0) chk({req, " tx_byte"}, bm_tx_byte_o, byte_v);
  endtask

  task automatic do_start(input int a, input bit rd, input bit ten, input int len);
    @(negedge clk);
    addr_i = 10'(a); rd_i = rd; ten_i = ten; len_i = LEN_W'(len); start_i = 1;
    @(negedge clk);
    start_i = 0;
    exp_cmd("R2 start", 1, -1);
    chk("R2 busy", busy_o, 1);
    chk("R11 err cleared on start", err_o, 0);
  endtask

  task automatic post(input int s, input int b);
    @(negedge clk);
    bm_status_valid_i = 1; bm_status_i = 8'(s); bm_rx_byte_i = 8'(b);
    @(negedge clk);
    bm_status_valid_i = 0;
  endtask

  task automatic exp_end(input string req, input int cmd, input int err);
    exp_cmd(req, cmd, -1);
    chk({req, " done"}, done_o, 1);
    chk({req, " err"}, err_o, err);
    chk({req, " busy"}, busy_o, 0);
  endtask

  function automatic int first_byte(input int a, input bit rd, input bit ten);
    if (ten) return 'hF0 | (((a >> 8) & 3) << 1) | int'(rd);
    return ((a & 'h7F) << 1) | int'(rd);
  endfunction

  task automatic send_addr(input int a, input bit rd, input bit ten);
    post('h08, 0);
    exp_cmd(ten ? "R4 first addr" : "R3 first addr", 2, first_byte(a, rd, ten));
    if (ten) begin
      post(rd ? 'h40 : 'h18, 0);
      exp_cmd("R4 second addr", 2, a & 'hFF);
      post(rd ? 'hE0 : 'hD0, 0);
    end else begin
      post(rd ? 'h40 : 'h18, 0);
    end
  endtask

  task automatic run_write(input int a, input bit ten, input int len);
    do_start(a, 0, ten, len);
    send_addr(a, 0, ten);
    for (int i = 0; i < len; i++) begin
      int d;
      d = (a + i * 37 + 5) & 'hFF;
      chk("R5 tx_ready raised", tx_ready_o, 1);
      chk("R5 no cmd while fetching", bm_cmd_valid_o, 0);
      @(negedge clk);
      chk("R5 still waiting for buffer", tx_ready_o, 1);
      tx_valid_i = 1; tx_data_i = 8'(d);
      @(negedge clk);
      tx_valid_i = 0;
      exp_cmd("R5 data byte", 2, d);
      chk("R5 tx_ready dropped", tx_ready_o, 0);
      post('h28, 0);
    end
    exp_end("R5 write end", 4, 0);
  endtask

  task automatic run_read(input int a, input bit ten, input int len);
    do_start(a, 1, ten, len);
    send_addr(a, 1, ten);
    if (len == 0) begin
      exp_end("R7 probe", 4, 0);
      return;
    end
    exp_cmd("R6 first rx", 3, -1);
    chk("R6 first ack", bm_ack_o, (len != 1) ? 1 : 0);
    for (int i = 0; i < len; i++) begin
      int rem, b;
      rem = len - i;
      b = (a * 3 + i * 29 + 1) & 'hFF;
      post(rem > 1 ? 'h50 : 'h58, b);
      chk("R6 rx_valid", rx_valid_o, 1);
      chk("R6 rx_data", rx_data_o, b);
      chk("R6 no cmd before delivery", bm_cmd_valid_o, 0);
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        chk("R12 rx_valid held", rx_valid_o, 1);
        chk("R12 rx_data held", rx_data_o, b);
        chk("R12 no cmd while stalled", bm_cmd_valid_o, 0);
      end
      rx_ready_i = 1;
      @(negedge clk);
      rx_ready_i = 0;
      chk("R12 rx_valid dropped", rx_valid_o, 0);
      if (rem == 1) exp_end("R6 read end", 4, 0);
      else begin
        exp_cmd("R6 next rx", 3, -1);
        chk("R6 ack for next", bm_ack_o, ((rem - 1) != 1) ? 1 : 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 cmd_valid", bm_cmd_valid_o, 0);
    chk("R1 tx_ready", tx_ready_o, 0);
    chk("R1 rx_valid", rx_valid_o, 0);
    chk("R1 err", err_o, 0);

    // R3 sweep over all 7-bit addresses (zero-length writes)
    for (int a = 0; a < 128; a++) run_write(a, 0, 0);

    for (int ten = 0; ten < 2; ten++)
      for (int len = 0; len < 5; len++)
        for (int k = 0; k < 6; k++) begin
          int a;
          a = (k * 'h93 + 'h15 + len * 7) & (ten ? 'h3FF : 'h7F);
          run_write(a, ten[0], len);
          run_read(a, ten[0], len);
        end

    // R2: start while busy ignored
    do_start('h2A, 0, 0, 0);
    post('h08, 0);
    exp_cmd("R3 first addr", 2, 'h54);
    @(negedge clk);
    addr_i = 10'h11; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R2 busy start no cmd", bm_cmd_valid_o, 0);
    chk("R2 busy start still busy", busy_o, 1);
    post('h18, 0);
    exp_end("R2 original message completes", 4, 0);

    // R8: address nack on write
    do_start('h50, 0, 0, 2);
    post('h08, 0);
    post('h20, 0);
    exp_end("R8 write addr nack", 4, 1);
    repeat (3) @(negedge clk);
    chk("R11 err held while idle", err_o, 1);
    // R10: status while idle
    post('h30, 0);
    exp_cmd("R10 idle status stop", 4, -1);
    chk("R10 no done", done_o, 0);
    chk("R10 err unchanged", err_o, 1);

    // R8: read address nack
    do_start('h33, 1, 0, 1);
    post('h10, 0);
    exp_cmd("R3 repeated start addr", 2, 'h67);
    post('h48, 0);
    exp_end("R8 read addr nack", 4, 1);

    // R8: data nack mid-write
    do_start('h12, 0, 0, 3);
    post('h08, 0);
    post('h18, 0);
    @(negedge clk);
    tx_valid_i = 1; tx_data_i = 8'hA5;
    @(negedge clk);
    tx_valid_i = 0;
    exp_cmd("R5 byte before nack", 2, 'hA5);
    post('h30, 0);
    exp_end("R8 data nack", 4, 1);

    // R9: unexpected statuses
    do_start('h40, 0, 0, 1);
    post('h38, 0);
    exp_end("R9 lost arbitration", 5, 2);
    repeat (2) @(negedge clk);
    chk("R11 io err held", err_o, 2);
    do_start('h155, 0, 1, 1);
    post('h08, 0);
    post('h18, 0);
    exp_cmd("R4 second addr", 2, 'h55);
    post('hD8, 0);
    exp_end("R9 second addr nack", 5, 2);
    do_start('h01, 1, 0, 0);
    post('h00, 0);
    exp_end("R9 bus error", 5, 2);

    do_start('h01, 1, 0, 0);
    post('h08, 0);
    post('h40, 0);
    exp_end("R7 probe after error", 4, 0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule